// File: doc/BRIEF.md
# Character LCD Parallel Bus Driver

This block is the host side of the parallel bus on a character LCD controller. A client hands it a request through a valid/ready handshake. The request carries a register-select bit, a direction bit, a byte and a bus-width choice. The engine then drives the RS, R/W, E and DB lines so that each bus cycle meets the controller's timing minimums. Every minimum is given in nanoseconds as a parameter. The number of clock cycles for each phase is the ceiling of that minimum divided by the clock period.

Before any request other than a status read, the engine reads the controller's status register until the busy bit is clear, and only then runs the requested transfer. Each bus beat passes through the states IDLE, SETUP, ENABLE, HOLD and GAP:
- IDLE to SETUP happens when a request is accepted.
- SETUP to ENABLE happens when the setup count expires. E rises at this point.
- ENABLE to HOLD happens when the pulse-width count expires. E falls at this point, and read data is sampled on this edge.
- HOLD to GAP happens when the hold count expires.
- GAP to SETUP happens in three cases: a second nibble is pending, a poll found the controller busy, or a poll found it free and the main transfer follows.
- GAP to IDLE happens when the last beat of the main transfer ends.

In 4-bit mode, each byte travels as two beats on the upper four data lines.

Top module: `lcd_bus_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the whole request, including its busy polls, has finished.
- R2: After reset, `req_ready`=1, `lcd_e`=0, `lcd_rw`=1, `lcd_db_oe`=0 and `rd_valid`=0.
- R3: `lcd_rs`, `lcd_rw`, `lcd_db_oe` and `lcd_db_out` stay unchanged for at least ceil(T_AS_NS/CLK_PERIOD_NS) cycles before E rises, which is 12 cycles at the defaults. They also stay unchanged while E is high.
- R4: E stays high for at least ceil(max(pulse width, write data setup, read access)/period) cycles, which is 90 cycles at the defaults.
- R5: After E falls, `lcd_rs`, `lcd_rw`, `lcd_db_oe` and `lcd_db_out` stay unchanged for at least ceil(max(address hold, write data hold, read data hold)/period) cycles, which is 4 cycles at the defaults.
- R6: Successive rising edges of E are at least ceil(T_CYCLE_NS/period) cycles apart, which is 200 cycles at the defaults.
- R7: During the main transfer, `lcd_rs` and `lcd_rw` equal the request's bits. The four codes are:
  - 0/0: instruction write
  - 0/1: status read
  - 1/0: data write
  - 1/1: data read

  On a write, the request byte is what the controller latches.
- R8: `lcd_db_oe` is low whenever `lcd_rw` is 1, and high during every write beat.
- R9: For every request other than a status read (RS=0, R/W=1), the engine first issues status reads. It repeats them until bit 7 of the status byte reads 0, then performs the request. A status-read request gets no poll in front of it.
- R10: When `req_nibble`=1, each byte is split into two beats:
  - The high nibble goes first and the low nibble second, both on DB[7:4].
  - DB[3:0] is driven 0.
  - On reads, the first nibble forms bits 7:4 and the second forms bits 3:0.
  - The busy bit is DB7 of the first nibble.
- R11: After a read request (R/W=1), `rd_valid` pulses for exactly one cycle, in the first cycle that `req_ready` is high again. `rd_data` holds the byte sampled on the last clock edge of E high. A write request produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_rs | input | 1 | Register select of the request |
| req_rw | input | 1 | Direction of the request, 1 = read |
| req_data | input | 8 | Byte to write |
| req_nibble | input | 1 | 1 = 4-bit bus transfer |
| rd_valid | output | 1 | One-cycle pulse: read result ready |
| rd_data | output | 8 | Read result |
| lcd_rs | output | 1 | Bus register select |
| lcd_rw | output | 1 | Bus read/write |
| lcd_e | output | 1 | Bus enable strobe |
| lcd_db_out | output | 8 | Data bus value driven by the host |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_in | input | 8 | Data bus value driven by the controller |

## Verification
The assertions assume that `req_nibble`, `req_rs`, `req_rw` and `req_data` only matter at the accepting edge. They also assume that `lcd_db_in` is stable at the edge where E falls, and that the controller clears its busy bit after a finite number of polls. The bench meets these assumptions as follows:
- Request fields change only at negative clock edges while the engine is idle.
- A bus model drives `lcd_db_in` from state that changes only on the falling half of the clock.
- After each write, the model stays busy for at most two status reads.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

    localparam int LCD_BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ENABLE,
        ST_HOLD,
        ST_GAP
    } lcd_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // A freshly loaded non-zero count must not report expiry on the next cycle
    AST_TIMER_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done); // R4

endmodule

// File: rtl/lcd_beat_data.sv
module lcd_beat_data
    import lcd_bus_pkg::*;
#(
    parameter int BYTE_W = LCD_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_mode,
    input  logic              low_half,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              cap_en,
    input  logic [BYTE_W-1:0] db_in,
    output logic [BYTE_W-1:0] db_out,
    output logic [BYTE_W-1:0] cap_byte
);

    localparam int HALF = BYTE_W / 2;

    // Lane steering: in narrow mode the upper lanes carry one nibble at a time
    for (genvar g = 0; g < HALF; g++) begin : g_lane
        assign db_out[g]      = nib_mode ? 1'b0 : wr_byte[g];
        assign db_out[HALF+g] = (nib_mode && low_half) ? wr_byte[g] : wr_byte[HALF+g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_byte <= '0;
        end else if (cap_en) begin
            if (!nib_mode) begin
                cap_byte <= db_in;
            end else if (!low_half) begin
                cap_byte[BYTE_W-1:HALF] <= db_in[BYTE_W-1:HALF];
            end else begin
                cap_byte[HALF-1:0] <= db_in[BYTE_W-1:HALF];
            end
        end
    end

    AST_NARROW_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        nib_mode |-> (db_out[HALF-1:0] == '0)); // R10

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
    import lcd_bus_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_CYCLE_NS    = 1000,
    parameter int T_PW_NS       = 450,
    parameter int T_AS_NS       = 60,
    parameter int T_AH_NS       = 20,
    parameter int T_DSW_NS      = 195,
    parameter int T_DHW_NS      = 10,
    parameter int T_DDR_NS      = 360,
    parameter int T_DHR_NS      = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic       req_rw,
    input  logic [7:0] req_data,
    input  logic       req_nibble,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in
);

    // ---------------- derived phase lengths ----------------
    localparam int CYC_AS_RAW = ceil_div(T_AS_NS, CLK_PERIOD_NS);
    localparam int CYC_AS     = imax(1, CYC_AS_RAW);
    localparam int CYC_PW     = imax(1, ceil_div(imax(T_PW_NS, imax(T_DSW_NS, T_DDR_NS)), CLK_PERIOD_NS));
    localparam int CYC_HOLD   = imax(1, ceil_div(imax(T_AH_NS, imax(T_DHW_NS, T_DHR_NS)), CLK_PERIOD_NS));
    localparam int CYC_TC     = ceil_div(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int CYC_GAP    = imax(1, CYC_TC - CYC_AS - CYC_PW - CYC_HOLD);
    localparam int CYC_MAX    = imax(imax(CYC_AS, CYC_PW), imax(CYC_HOLD, CYC_GAP));
    localparam int TW         = $clog2(CYC_MAX + 1);
    localparam int AW         = $clog2(CYC_TC + CYC_MAX + 8) + 1;
    localparam int CTL_W      = LCD_BYTE_W + 3;

    // ---------------- state and context ----------------
    lcd_state_e state_q, state_d;

    logic          q_rs, q_rw, q_nib;
    logic [7:0]    q_data;
    logic          is_poll;
    logic          second;
    logic          beat_rs, beat_rw, last_half;
    logic          busy_bit;
    logic          cap_en;
    logic [7:0]    cap_byte;
    logic [7:0]    beat_db;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          gap_end;
    logic          accept;

    assign beat_rs   = is_poll ? 1'b0 : q_rs;
    assign beat_rw   = is_poll ? 1'b1 : q_rw;
    assign last_half = !q_nib || second;
    assign busy_bit  = cap_byte[7];
    assign gap_end   = (state_q == ST_GAP) && tmr_done;
    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign cap_en    = (state_q == ST_ENABLE) && tmr_done && beat_rw;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SETUP;
            ST_SETUP:  if (tmr_done)  state_d = ST_ENABLE;
            ST_ENABLE: if (tmr_done)  state_d = ST_HOLD;
            ST_HOLD:   if (tmr_done)  state_d = ST_GAP;
            ST_GAP:    if (tmr_done)  state_d = (!last_half || is_poll) ? ST_SETUP : ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        tmr_val  = '0;
        unique case (state_d)
            ST_SETUP:  tmr_val = TW'(CYC_AS - 1);
            ST_ENABLE: tmr_val = TW'(CYC_PW - 1);
            ST_HOLD:   tmr_val = TW'(CYC_HOLD - 1);
            ST_GAP:    tmr_val = TW'(CYC_GAP - 1);
            default:   tmr_val = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- request context and sequencing ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_rs     <= 1'b0;
            q_rw     <= 1'b1;
            q_nib    <= 1'b0;
            q_data   <= '0;
            is_poll  <= 1'b0;
            second   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                q_rs    <= req_rs;
                q_rw    <= req_rw;
                q_nib   <= req_nibble;
                q_data  <= req_data;
                is_poll <= !(!req_rs && req_rw);
                second  <= 1'b0;
            end else if (gap_end) begin
                if (!last_half) begin
                    second <= 1'b1;
                end else begin
                    second <= 1'b0;
                    if (is_poll && !busy_bit) is_poll <= 1'b0;
                    if (!is_poll && q_rw) begin
                        rd_valid <= 1'b1;
                        rd_data  <= cap_byte;
                    end
                end
            end
        end
    end

    // ---------------- submodules ----------------
    lcd_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    lcd_beat_data #(.BYTE_W(LCD_BYTE_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .nib_mode (q_nib),
        .low_half (second),
        .wr_byte  (q_data),
        .cap_en   (cap_en),
        .db_in    (lcd_db_in),
        .db_out   (beat_db),
        .cap_byte (cap_byte)
    );

    // ---------------- outputs ----------------
    always_comb begin
        req_ready  = 1'b0;
        lcd_e      = 1'b0;
        lcd_rs     = beat_rs;
        lcd_rw     = beat_rw;
        lcd_db_oe  = !beat_rw;
        lcd_db_out = beat_db;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                lcd_rs    = 1'b0;
                lcd_rw    = 1'b1;
                lcd_db_oe = 1'b0;
            end
            ST_ENABLE: lcd_e = 1'b1;
            ST_SETUP, ST_HOLD, ST_GAP: lcd_e = 1'b0;
            default: lcd_e = 1'b0;
        endcase
    end

    // ---------------- checking support ----------------
    logic             e_q;
    logic [CTL_W-1:0] ctl_now, ctl_q;
    logic             ctl_chg;
    logic [AW-1:0]    ctl_age, hi_cnt, rise_age, fall_age;
    logic             rose_seen, fell_seen;

    assign ctl_now = {lcd_rs, lcd_rw, lcd_db_oe, lcd_db_out};
    assign ctl_chg = (ctl_now != ctl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= 1'b0;
            ctl_q     <= {1'b0, 1'b1, 1'b0, {LCD_BYTE_W{1'b0}}};
            ctl_age   <= '0;
            hi_cnt    <= '0;
            rise_age  <= '0;
            fall_age  <= '0;
            rose_seen <= 1'b0;
            fell_seen <= 1'b0;
        end else begin
            e_q      <= lcd_e;
            ctl_q    <= ctl_now;
            ctl_age  <= ctl_chg ? AW'(1) : ((&ctl_age) ? ctl_age : ctl_age + 1'b1);
            hi_cnt   <= lcd_e ? hi_cnt + 1'b1 : '0;
            rise_age <= (lcd_e && !e_q) ? AW'(1) : ((&rise_age) ? rise_age : rise_age + 1'b1);
            fall_age <= (!lcd_e && e_q) ? AW'(1) : ((&fall_age) ? fall_age : fall_age + 1'b1);
            if (lcd_e && !e_q) rose_seen <= 1'b1;
            if (!lcd_e && e_q) fell_seen <= 1'b1;
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lcd_e); // R1
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_SETUP_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_q) |-> (ctl_age >= AW'(CYC_AS))); // R3
    AST_BUS_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && e_q) |-> !ctl_chg); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && e_q) |-> (hi_cnt >= AW'(CYC_PW))); // R4
    AST_HOLD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_chg && fell_seen && !lcd_e) |-> (fall_age >= AW'(CYC_HOLD))); // R5
    AST_CYCLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_q && rose_seen) |-> (rise_age >= AW'(CYC_TC))); // R6
    AST_OE_OFF_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw |-> !lcd_db_oe); // R8
    AST_RDV_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> req_ready); // R11
    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R11

endmodule

// File: tb/tb_lcd_bus_engine.sv
`timescale 1ns/1ps
module tb_lcd_bus_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_rs = 1'b0;
    logic       req_rw = 1'b0;
    logic [7:0] req_data = '0;
    logic       req_nibble = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
    logic [7:0] lcd_db_out;
    logic [7:0] lcd_db_in;

    always #2.5 clk = ~clk;

    lcd_bus_engine dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_rs(req_rs), .req_rw(req_rw), .req_data(req_data), .req_nibble(req_nibble),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
        .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
    );

    // expected phase floors at a 5 ns clock
    localparam int EXP_AS = 12;
    localparam int EXP_PW = 90;
    localparam int EXP_HD = 4;
    localparam int EXP_TC = 200;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- controller model ----------------
    logic       m_nib = 1'b0;
    logic       half = 1'b0;
    int         busy_left = 0;
    logic [7:0] rd_val = 8'h00;
    logic [6:0] ac_val = 7'h00;
    logic [7:0] acc = 8'h00;
    int         status_cnt = 0, wr_cnt = 0, drd_cnt = 0;
    logic       wr_rs = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    int         status_before_wr = 0;

    logic        e_prev = 1'b0;
    logic [10:0] ctl_prev = 11'b0_1_0_00000000;
    int          hi = 0, ctl_age = 0, since_rise = 0, since_fall = 0;
    bit          seen_rise = 0, seen_fall = 0;

    logic [7:0] sel_byte;
    always_comb begin
        sel_byte  = lcd_rs ? rd_val : {busy_left != 0, ac_val};
        lcd_db_in = m_nib ? {(half ? sel_byte[3:0] : sel_byte[7:4]), 4'h0} : sel_byte;
    end

    always @(negedge clk) begin
        logic [10:0] ctl_now;
        bit chg, done;
        ctl_now = {lcd_rs, lcd_rw, lcd_db_oe, lcd_db_out};
        chg = (ctl_now != ctl_prev);
        if (rst_n) begin
            if (lcd_e && !e_prev) begin
                chk(ctl_age >= EXP_AS, "R3", "setup cycles before E rise", ctl_age, EXP_AS);
                if (seen_rise) chk(since_rise >= EXP_TC, "R6", "E rise spacing", since_rise, EXP_TC);
            end
            if (lcd_e && e_prev && chg)
                chk(0, "R3", "bus moved while E high", ctl_now, ctl_prev);
            if (chg && !lcd_e && seen_fall && since_fall < EXP_HD)
                chk(0, "R5", "hold cycles after E fall", since_fall, EXP_HD);
            if (!lcd_e && e_prev) begin
                chk(hi >= EXP_PW, "R4", "E high cycles", hi, EXP_PW);
                if (!lcd_rw) begin
                    chk(lcd_db_oe == 1'b1, "R8", "oe on write beat", lcd_db_oe, 1);
                    if (m_nib) begin
                        chk(lcd_db_out[3:0] == 4'h0, "R10", "low lanes in 4-bit", lcd_db_out[3:0], 0);
                        if (!half) acc[7:4] = lcd_db_out[7:4];
                        else       acc[3:0] = lcd_db_out[7:4];
                    end else acc = lcd_db_out;
                end else begin
                    chk(lcd_db_oe == 1'b0, "R8", "oe on read beat", lcd_db_oe, 0);
                end
                done = !m_nib || half;
                if (m_nib) half = ~half;
                if (done) begin
                    if (!lcd_rw) begin
                        wr_cnt++; wr_rs = lcd_rs; wr_byte = acc;
                        status_before_wr = status_cnt;
                        busy_left = $urandom_range(0, 2);
                    end else if (!lcd_rs) begin
                        status_cnt++;
                        if (busy_left > 0) busy_left--;
                    end else begin
                        drd_cnt++;
                        chk(status_cnt >= 1, "R9", "poll before data read", status_cnt, 1);
                    end
                end
            end
            ctl_age    = chg ? 1 : ctl_age + 1;
            since_rise = (lcd_e && !e_prev) ? 1 : since_rise + 1;
            since_fall = (!lcd_e && e_prev) ? 1 : since_fall + 1;
            if (lcd_e && !e_prev) seen_rise = 1;
            if (!lcd_e && e_prev) seen_fall = 1;
            hi = lcd_e ? hi + 1 : 0;
        end
        ctl_prev = ctl_now;
        e_prev   = lcd_e;
    end

    // ---------------- request driver ----------------
    task automatic do_req(input logic rs, input logic rw, input logic [7:0] data, input logic nib);
        int busy0;
        bit is_stat;
        logic [7:0] exp_rd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        m_nib = nib; half = 0; status_cnt = 0; wr_cnt = 0; drd_cnt = 0;
        rd_val = 8'($urandom); ac_val = 7'($urandom);
        busy0 = busy_left;
        is_stat = (!rs && rw);
        exp_rd = is_stat ? {busy0 != 0, ac_val} : rd_val;
        req_valid = 1; req_rs = rs; req_rw = rw; req_data = data; req_nibble = nib;
        @(negedge clk);
        req_valid = 0; req_data = 8'($urandom); req_nibble = 1'($urandom);
        chk(req_ready == 1'b0, "R1", "ready low after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        chk(rd_valid == rw, "R11", "rd_valid on return to idle", rd_valid, rw);
        if (rw) chk(rd_data == exp_rd, nib ? "R10" : "R11", "read byte", rd_data, exp_rd);
        if (is_stat) begin
            chk(status_cnt == 1, "R9", "status request without poll", status_cnt, 1);
        end else if (rw) begin
            chk(status_cnt == busy0 + 1, "R9", "polls before data read", status_cnt, busy0 + 1);
            chk(drd_cnt == 1, "R7", "one data read", drd_cnt, 1);
        end else begin
            chk(status_before_wr == busy0 + 1, "R9", "polls before write", status_before_wr, busy0 + 1);
            chk(wr_cnt == 1, "R7", "one write", wr_cnt, 1);
            chk(wr_rs == rs, "R7", "rs of write", wr_rs, rs);
            chk(wr_byte == data, nib ? "R10" : "R7", "written byte", wr_byte, data);
        end
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11", "rd_valid one cycle", rd_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
        chk(lcd_e == 1'b0, "R2", "E after reset", lcd_e, 0);
        chk(lcd_rw == 1'b1, "R2", "rw after reset", lcd_rw, 1);
        chk(lcd_db_oe == 1'b0, "R2", "oe after reset", lcd_db_oe, 0);
        chk(rd_valid == 1'b0, "R2", "rd_valid after reset", rd_valid, 0);

        // directed corners
        busy_left = 0; do_req(1'b0, 1'b0, 8'h38, 1'b0);   // R7 instruction write, idle controller
        busy_left = 2; do_req(1'b0, 1'b0, 8'h0C, 1'b0);   // R9 two busy polls
        busy_left = 2; do_req(1'b0, 1'b1, 8'h00, 1'b0);   // R9 status read reports busy, no poll
        busy_left = 1; do_req(1'b1, 1'b0, 8'hA5, 1'b1);   // R10 nibble write
        busy_left = 2; do_req(1'b1, 1'b1, 8'h00, 1'b1);   // R10 nibble read after polls
        busy_left = 0; do_req(1'b0, 1'b1, 8'h00, 1'b1);   // R10 nibble status read
        busy_left = 0; do_req(1'b1, 1'b0, 8'hFF, 1'b0);   // R7 data write all ones
        busy_left = 0; do_req(1'b1, 1'b0, 8'h00, 1'b1);   // R10 nibble write zero

        // constrained random mix
        for (int i = 0; i < 45; i++) begin
            do_req(1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule